// File: doc/BRIEF.md
# Data Memory Space Router

This block sits between the data-access side of an 8-bit microcontroller core and four physically separate storage spaces: a 256-byte internal data RAM, an on-chip expanded RAM, an external special-function-register (SFR) block and an external data bus. The core presents one access per cycle. For an internal access it gives an 8-bit address and a flag that says whether the instruction used direct or indirect addressing. For an external-data (MOVX) access it gives a 16-bit address. The router picks the destination, drives the matching select and write enable in the same cycle, and returns read data one cycle later.

The upper half of the 8-bit space (80H–FFH) is shared by two stores. Indirect accesses there reach the upper 128 bytes of RAM. Direct accesses reach the SFRs. A configuration bit, loaded by the core, moves all MOVX traffic to the external bus. While that bit is clear, MOVX addresses below the expanded RAM size stay on chip. Both arrays are written so that they map onto block RAM.

Top module: `dmem_router`

## Requirements
- R1: An internal access (movx low) with address 00H–7FH reaches the internal RAM whether mode_ind is 0 (direct) or 1 (indirect). A byte written in one mode reads back in the other.
- R2: An internal access with address 80H–FFH and mode_ind = 1 reaches the upper internal RAM. sfr_sel stays low.
- R3: An internal access with address 80H–FFH and mode_ind = 0 raises sfr_sel, and also sfr_we when it is a write. It never reads or writes the internal RAM.
- R4: The upper RAM and the SFRs are separate storage. A direct write to A0H leaves the RAM byte at A0H unchanged, and an indirect write to A0H does not raise sfr_sel.
- R5: A MOVX access with xaddr below XRAM_BYTES (256 or 1024) while EXTRAM is clear reaches the on-chip expanded RAM, and ext_sel stays low.
- R6: A MOVX access with xaddr at or above XRAM_BYTES raises ext_sel (and ext_we when writing). It leaves the expanded RAM unchanged, and the address does not wrap onto a low byte.
- R7: EXTRAM is loaded from cfg_extram on a clock edge where cfg_load is 1. While EXTRAM is 1, every MOVX access raises ext_sel and leaves the expanded RAM untouched.
- R8: A read (rd = 1, wr = 0) sets rd_valid and presents rdata on the next cycle. The data comes from the space selected in the strobe cycle. For SFR and bus reads, the value of sfr_rdata or ext_rdata in the strobe cycle is returned.
- R9: While rst is 1, no select or write enable is raised and rd_valid is 0. After reset, EXTRAM is 0.
- R10: A write raises the enable of exactly one destination in the strobe cycle. When rd and wr are both 1, the write is performed and no read result is produced (rd_valid stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iaddr | input | 8 | Internal data address |
| xaddr | input | 16 | MOVX address |
| mode_ind | input | 1 | 1 = indirect addressing, 0 = direct |
| movx | input | 1 | 1 = MOVX access using xaddr |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| cfg_load | input | 1 | Load EXTRAM from cfg_extram |
| cfg_extram | input | 1 | New EXTRAM value |
| sfr_rdata | input | 8 | Read data from the SFR block |
| ext_rdata | input | 8 | Read data from the external bus |
| sfr_sel | output | 1 | SFR block select |
| sfr_we | output | 1 | SFR write enable |
| sfr_addr | output | 8 | SFR address |
| ext_sel | output | 1 | External bus select |
| ext_we | output | 1 | External bus write enable |
| ext_addr | output | 16 | External bus address |
| bus_wdata | output | 8 | Write data to SFR block and bus |
| rdata | output | 8 | Read data, one cycle after the strobe |
| rd_valid | output | 1 | rdata holds a read result |

## Verification
The bench overrides XRAM_BYTES to 256. This puts the top expanded byte (00FFH) and the first external address (0100H) next to each other, so a test can check that 0100H does not wrap onto byte 0000H. The same override makes an 8-bit index for the array, so a truncation fault in the range compare would show up as corrupted low bytes. The default of 1024 differs only in that limit and in the array depth.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  typedef enum logic [2:0] {
    DST_NONE = 3'd0,
    DST_IRAM = 3'd1,
    DST_SFR  = 3'd2,
    DST_XRAM = 3'd3,
    DST_EXT  = 3'd4
  } dest_e;
endpackage

// File: rtl/dmem_spram.sv
module dmem_spram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wd,
  output logic [WIDTH-1:0] rq
);
  logic [WIDTH-1:0] mem [DEPTH];

  // No reset on storage or read register so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) rq <= mem[addr];
  end
endmodule

// File: rtl/dmem_decode.sv
module dmem_decode
  import dmem_pkg::*;
#(
  parameter int XRAM_BYTES = 1024
) (
  input  logic        rst,
  input  logic        rd,
  input  logic        wr,
  input  logic        movx,
  input  logic        mode_ind,
  input  logic        iaddr_hi,
  input  logic [15:0] xaddr,
  input  logic        extram,
  output dest_e       dest
);
  localparam logic [16:0] XLIMIT = 17'(XRAM_BYTES);

  logic acc, on_chip_x;
  assign acc       = (rd | wr) & ~rst;
  assign on_chip_x = ({1'b0, xaddr} < XLIMIT) & ~extram;

  always_comb begin
    dest = DST_NONE;
    if (acc) begin
      if (movx)                       dest = on_chip_x ? DST_XRAM : DST_EXT;
      else if (iaddr_hi && !mode_ind) dest = DST_SFR;
      else                            dest = DST_IRAM;
    end
  end
endmodule

// File: rtl/dmem_router.sv
module dmem_router
  import dmem_pkg::*;
#(
  parameter int XRAM_BYTES = 1024,
  parameter int IRAM_BYTES = 256,
  localparam int XAW = $clog2(XRAM_BYTES),
  localparam int IAW = $clog2(IRAM_BYTES)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  iaddr,
  input  logic [15:0] xaddr,
  input  logic        mode_ind,
  input  logic        movx,
  input  logic        rd,
  input  logic        wr,
  input  logic [7:0]  wdata,
  input  logic        cfg_load,
  input  logic        cfg_extram,
  input  logic [7:0]  sfr_rdata,
  input  logic [7:0]  ext_rdata,
  output logic        sfr_sel,
  output logic        sfr_we,
  output logic [7:0]  sfr_addr,
  output logic        ext_sel,
  output logic        ext_we,
  output logic [15:0] ext_addr,
  output logic [7:0]  bus_wdata,
  output logic [7:0]  rdata,
  output logic        rd_valid
);
  dest_e      dest, dest_q;
  logic       extram_q;
  logic       iram_en, xram_en, iram_we, xram_we, rd_only;
  logic [7:0] iram_q, xram_q, cap_q;

  always_ff @(posedge clk) begin
    if (rst)           extram_q <= 1'b0;
    else if (cfg_load) extram_q <= cfg_extram;
  end

  dmem_decode #(.XRAM_BYTES(XRAM_BYTES)) u_decode (
    .rst      (rst),
    .rd       (rd),
    .wr       (wr),
    .movx     (movx),
    .mode_ind (mode_ind),
    .iaddr_hi (iaddr[7]),
    .xaddr    (xaddr),
    .extram   (extram_q),
    .dest     (dest)
  );

  assign rd_only = rd & ~wr;
  assign iram_en = (dest == DST_IRAM);
  assign xram_en = (dest == DST_XRAM);
  assign iram_we = iram_en & wr;
  assign xram_we = xram_en & wr;
  assign sfr_sel = (dest == DST_SFR);
  assign ext_sel = (dest == DST_EXT);
  assign sfr_we  = sfr_sel & wr;
  assign ext_we  = ext_sel & wr;

  assign sfr_addr  = iaddr;
  assign ext_addr  = xaddr;
  assign bus_wdata = wdata;

  dmem_spram #(.DEPTH(IRAM_BYTES), .WIDTH(8)) u_iram (
    .clk  (clk),
    .we   (iram_we),
    .re   (iram_en & rd_only),
    .addr (iaddr[IAW-1:0]),
    .wd   (wdata),
    .rq   (iram_q)
  );

  dmem_spram #(.DEPTH(XRAM_BYTES), .WIDTH(8)) u_xram (
    .clk  (clk),
    .we   (xram_we),
    .re   (xram_en & rd_only),
    .addr (xaddr[XAW-1:0]),
    .wd   (wdata),
    .rq   (xram_q)
  );

  // Track which space answers the read, and capture off-block read data.
  always_ff @(posedge clk) begin
    if (rst) begin
      dest_q   <= DST_NONE;
      rd_valid <= 1'b0;
      cap_q    <= 8'h00;
    end else begin
      dest_q   <= rd_only ? dest : DST_NONE;
      rd_valid <= rd_only && (dest != DST_NONE);
      if (rd_only && sfr_sel) cap_q <= sfr_rdata;
      if (rd_only && ext_sel) cap_q <= ext_rdata;
    end
  end

  always_comb begin
    unique case (dest_q)
      DST_IRAM:         rdata = iram_q;
      DST_XRAM:         rdata = xram_q;
      DST_SFR, DST_EXT: rdata = cap_q;
      default:          rdata = 8'h00;
    endcase
  end

  // R10: a write enables exactly one destination
  assert_one_dest_R10: assert property (@(posedge clk) disable iff (rst)
    wr |-> $countones({iram_we, sfr_we, xram_we, ext_we}) == 1);

  // R3: SFR select only for direct, upper-half, non-MOVX accesses
  assert_sfr_direct_only_R3: assert property (@(posedge clk) disable iff (rst)
    sfr_sel |-> (!mode_ind && iaddr[7] && !movx && !iram_en));

  // R2/R4: indirect upper-half accesses never reach the SFR port
  assert_ind_no_sfr_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_ind && !movx) |-> !sfr_sel);

  // R6: on-chip expanded RAM only below its size
  assert_xram_bound_R6: assert property (@(posedge clk) disable iff (rst)
    xram_en |-> ({1'b0, xaddr} < 17'(XRAM_BYTES)));

  // R7: with EXTRAM set all MOVX goes out
  assert_extram_out_R7: assert property (@(posedge clk) disable iff (rst)
    (movx && extram_q && (rd || wr)) |-> (ext_sel && !xram_en));

  // R8: a read gives a result next cycle
  assert_read_latency_R8: assert property (@(posedge clk) disable iff (rst)
    (rd && !wr) |=> rd_valid);

  // R9: reset clears EXTRAM and the read result flag
  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> (!extram_q && !rd_valid));

  // R9: no select while in reset
  assert_reset_quiet_R9: assert property (@(posedge clk)
    rst |-> (!sfr_sel && !ext_sel && !iram_en && !xram_en));
endmodule

// File: tb/tb_dmem_router.sv
`timescale 1ns/1ps
module tb_dmem_router;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  iaddr;
  logic [15:0] xaddr;
  logic        mode_ind, movx, rd, wr, cfg_load, cfg_extram;
  logic [7:0]  wdata;
  logic [7:0]  sfr_rdata = 8'h5A;
  logic [7:0]  ext_rdata = 8'hC3;
  logic        sfr_sel, sfr_we, ext_sel, ext_we, rd_valid;
  logic [7:0]  sfr_addr, bus_wdata, rdata;
  logic [15:0] ext_addr;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  dmem_router #(.XRAM_BYTES(256)) dut (
    .clk(clk), .rst(rst), .iaddr(iaddr), .xaddr(xaddr), .mode_ind(mode_ind),
    .movx(movx), .rd(rd), .wr(wr), .wdata(wdata), .cfg_load(cfg_load),
    .cfg_extram(cfg_extram), .sfr_rdata(sfr_rdata), .ext_rdata(ext_rdata),
    .sfr_sel(sfr_sel), .sfr_we(sfr_we), .sfr_addr(sfr_addr), .ext_sel(ext_sel),
    .ext_we(ext_we), .ext_addr(ext_addr), .bus_wdata(bus_wdata),
    .rdata(rdata), .rd_valid(rd_valid)
  );

  // Vector: op[37:36] (1 write, 2 read), movx[35], ind[34], addr[33:18],
  // wdata[17:10], exp sfr_sel[9], exp ext_sel[8], exp rdata[7:0]
  localparam int NV = 15;
  localparam logic [37:0] VEC [NV] = '{
    {2'd1, 1'b0, 1'b0, 16'h0010, 8'h11, 1'b0, 1'b0, 8'h00},
    {2'd2, 1'b0, 1'b1, 16'h0010, 8'h00, 1'b0, 1'b0, 8'h11},
    {2'd1, 1'b0, 1'b1, 16'h007F, 8'h77, 1'b0, 1'b0, 8'h00},
    {2'd2, 1'b0, 1'b0, 16'h007F, 8'h00, 1'b0, 1'b0, 8'h77},
    {2'd1, 1'b0, 1'b1, 16'h00A0, 8'h22, 1'b0, 1'b0, 8'h00},
    {2'd1, 1'b0, 1'b0, 16'h00A0, 8'h99, 1'b1, 1'b0, 8'h00},
    {2'd2, 1'b0, 1'b1, 16'h00A0, 8'h00, 1'b0, 1'b0, 8'h22},
    {2'd2, 1'b0, 1'b0, 16'h00A0, 8'h00, 1'b1, 1'b0, 8'h5A},
    {2'd1, 1'b1, 1'b0, 16'h0000, 8'h66, 1'b0, 1'b0, 8'h00},
    {2'd1, 1'b1, 1'b0, 16'h00FF, 8'h44, 1'b0, 1'b0, 8'h00},
    {2'd1, 1'b1, 1'b0, 16'h0100, 8'h55, 1'b0, 1'b1, 8'h00},
    {2'd2, 1'b1, 1'b0, 16'h0000, 8'h00, 1'b0, 1'b0, 8'h66},
    {2'd2, 1'b1, 1'b0, 16'h00FF, 8'h00, 1'b0, 1'b0, 8'h44},
    {2'd2, 1'b1, 1'b0, 16'h0100, 8'h00, 1'b0, 1'b1, 8'hC3},
    {2'd2, 1'b1, 1'b0, 16'hFFFF, 8'h00, 1'b0, 1'b1, 8'hC3}
  };

  function automatic string vtag(int i);
    if (i < 4)       return "R1";
    else if (i == 4) return "R2";
    else if (i == 5) return "R3";
    else if (i == 6) return "R4";
    else if (i == 7) return "R3";
    else if (i == 10 || i >= 13) return "R6";
    else if (i == 11) return "R6";
    else             return "R5";
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    rd = 0; wr = 0; movx = 0; mode_ind = 0; iaddr = 0; xaddr = 0; wdata = 0;
    cfg_load = 0; cfg_extram = 0;
  endtask

  // Drive one access at a falling edge, check selects before the rising edge,
  // and for reads check rdata at the following falling edge.
  task automatic access(bit w, bit r, bit mx, bit ind, logic [15:0] a,
                        logic [7:0] wd, bit esfr, bit eext, bit ckrd,
                        logic [7:0] erd, string tag);
    @(negedge clk);
    wr = w; rd = r; movx = mx; mode_ind = ind;
    iaddr = a[7:0]; xaddr = a; wdata = wd;
    #1;
    chk(tag, "sfr_sel", {15'd0, sfr_sel}, {15'd0, esfr});
    chk(tag, "ext_sel", {15'd0, ext_sel}, {15'd0, eext});
    if (w) begin
      chk(tag, "sfr_we", {15'd0, sfr_we}, {15'd0, esfr});
      chk(tag, "ext_we", {15'd0, ext_we}, {15'd0, eext});
    end
    @(negedge clk);
    idle();
    if (ckrd) begin
      chk(tag, "rd_valid", {15'd0, rd_valid}, 16'd1);
      chk(tag, "rdata", {8'd0, rdata}, {8'd0, erd});
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1;
    // R9: strobes during reset raise nothing
    @(negedge clk);
    wr = 1; movx = 1; xaddr = 16'h0200; #1;
    chk("R9", "ext_sel in reset", {15'd0, ext_sel}, 16'd0);
    wr = 0; rd = 1; movx = 0; iaddr = 8'hA0; #1;
    chk("R9", "sfr_sel in reset", {15'd0, sfr_sel}, 16'd0);
    @(negedge clk);
    chk("R9", "rd_valid in reset", {15'd0, rd_valid}, 16'd0);
    idle();
    @(negedge clk);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][37:36] == 2'd1, VEC[i][37:36] == 2'd2, VEC[i][35], VEC[i][34],
             VEC[i][33:18], VEC[i][17:10], VEC[i][9], VEC[i][8],
             VEC[i][37:36] == 2'd2, VEC[i][7:0], vtag(i));
    end

    // R10: rd and wr together: write done, no read result
    access(1, 1, 0, 0, 16'h0020, 8'h31, 0, 0, 0, 8'h00, "R10");
    chk("R10", "rd_valid after rd+wr", {15'd0, rd_valid}, 16'd0);
    access(0, 1, 0, 1, 16'h0020, 8'h00, 0, 0, 1, 8'h31, "R10");

    // R7: set EXTRAM, MOVX goes to bus even below the size
    @(negedge clk);
    cfg_load = 1; cfg_extram = 1;
    @(negedge clk);
    idle();
    access(1, 0, 1, 0, 16'h00FF, 8'hEE, 0, 1, 0, 8'h00, "R7");
    access(0, 1, 1, 0, 16'h0000, 8'h00, 0, 1, 1, 8'hC3, "R7");

    // R9: reset clears EXTRAM; R7: on-chip byte untouched by the bus write
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    access(0, 1, 1, 0, 16'h00FF, 8'h00, 0, 0, 1, 8'h44, "R9");

    // R8: read of an idle cycle leaves rd_valid low
    @(negedge clk);
    chk("R8", "rd_valid idle", {15'd0, rd_valid}, 16'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule